// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is an 8-bit serial shift engine for a three-wire link made of a serial clock, a data input and a data output. It can run as master or as slave. As master, the host makes the serial clock by writing a toggle command, and each write produces one clock edge. As slave, an external clock drives the engine. That external clock and the data input are first synchronized to the system clock, and their edges are found in the system clock domain.

Every serial clock edge counts, rising and falling. One edge of each pulse samples the data input into a holding latch. The opposite edge shifts the register one place: the latched bit enters at the least significant end, and the output pin always shows the most significant bit. After sixteen edges the transfer is complete, so a sticky flag is set and an interrupt request is raised. The received byte then stays in the data register until the host clears the flag and loads the next byte.

The host reaches three registers through a small write/read bus. Address 0 is the data register. Address 1 is the configuration register: the clock mode, the master select, and read-only status. Address 2 takes write-only commands.

Top module: `tws_shift_unit`

## Requirements
- R1: After reset the data register, edge counter and done flag are 0, and sckOut, sdo and irq are low.
- R2: sdo always equals bit 7 of the data register. Each shifting edge moves the register one place toward bit 7 and puts the latched input bit into bit 0. After eight pulses the register holds the input bits, the first one sampled ending up in bit 7.
- R3: Configuration bit 0 selects the clock mode. In mode 0 the data input is sampled on rising edges and the register shifts on falling edges. In mode 1 it is sampled on falling edges and shifts on rising edges. A sampling edge leaves the data register unchanged.
- R4: The edge counter advances by one on every accepted edge, rising or falling. It reads back in bits 7:4 of address 1.
- R5: The edge that takes the counter from 15 back to 0 sets the done flag, which reads in bit 3 of address 1 and drives irq high.
- R6: Writing address 2 with bit 0 set inverts sckOut in the next cycle. In master mode (configuration bit 1 = 1) each such write is exactly one serial clock edge.
- R7: Writing address 2 with bit 1 set clears the done flag, and also clears the counter; irq falls.
- R8: While the done flag is set, serial clock edges are ignored: the data register and the counter keep their values.
- R9: Writing address 0 loads the byte and clears the counter without changing the done flag. If an edge arrives in the same cycle, the load wins and the edge is dropped.
- R10: In slave mode (configuration bit 1 = 0), edges of sckIn are accepted after the synchronizer delay. A configuration write sets sckOut to the idle level given by the mode bit. Any level change of the selected clock line in the cycle after a configuration write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 data, 1 configuration, 2 command) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (command address reads 0) |
| sckIn | input | 1 | External serial clock for slave mode |
| sdi | input | 1 | Serial data input |
| sckOut | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data output (register MSB) |
| irq | output | 1 | Transfer-done interrupt request |

## Verification
A host load of the data register and a serial clock edge can fall in the same cycle. So can a flag-clear command and a counted edge. The bench provokes the first case in master mode. It writes a toggle command, then writes address 0 in the very next cycle, which is the cycle the toggled line is detected as an edge. Afterwards the data register must hold the written byte unshifted and the counter must read 0. The clear-versus-edge case is judged the same way, mid-transfer: after the clear, the counter must read 0 and later edges must count again from 1.

// File: rtl/tws_pkg.sv
package tws_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // host write of a new byte
    logic sample;  // capture the synchronized input bit
    logic shift;   // move the register one place toward the MSB
  } dpStrobes_t;
endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic [DATA_W-1:0] loadByte,
  input  logic              sdiBit,
  output logic [DATA_W-1:0] dataQ,
  output logic              sdo
);
  logic sampleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ <= 1'b0;
    end else if (stb.sample) begin
      sampleQ <= sdiBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (stb.load) begin
      dataQ <= loadByte;
    end else if (stb.shift) begin
      dataQ <= {dataQ[DATA_W-2:0], sampleQ};
    end
  end

  assign sdo = dataQ[DATA_W-1];

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> dataQ == $past(loadByte));
  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.load) |=> dataQ[DATA_W-1:1] == $past(dataQ[DATA_W-2:0]));
  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && !stb.shift && !stb.load) |=> $stable(dataQ));
endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgMode,
  input  logic             cfgMaster,
  input  logic             toggleReq,
  input  logic             clrReq,
  input  logic             loadReq,
  input  logic             sckIn,
  input  logic             sdiIn,
  output dpStrobes_t       stb,
  output logic             sdiBit,
  output logic             sckOutQ,
  output logic             modeQ,
  output logic             masterQ,
  output logic             flagQ,
  output logic [CNT_W-1:0] cntQ
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * DATA_W - 1);

  logic sckSync;
  logic lineLevel, prevLine, maskQ;
  logic edgeOk, risingEdge, sampleEdge;

  // Synchronizers for the external clock and data input
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic sckR, sdiR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckR <= 1'b0;
          sdiR <= 1'b0;
        end else begin
          sckR <= sckIn;
          sdiR <= sdiIn;
        end
      end
      assign sckSync = sckR;
      assign sdiBit  = sdiR;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] sckPipe, sdiPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe <= '0;
          sdiPipe <= '0;
        end else begin
          sckPipe <= {sckPipe[SYNC_STAGES-2:0], sckIn};
          sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdiIn};
        end
      end
      assign sckSync = sckPipe[SYNC_STAGES-1];
      assign sdiBit  = sdiPipe[SYNC_STAGES-1];
    end
  endgenerate

  // Configuration and master clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      masterQ <= 1'b0;
      sckOutQ <= 1'b0;
      maskQ   <= 1'b0;
    end else begin
      maskQ <= cfgWr;
      if (cfgWr) begin
        modeQ   <= cfgMode;
        masterQ <= cfgMaster;
        sckOutQ <= cfgMode;
      end else if (toggleReq) begin
        sckOutQ <= ~sckOutQ;
      end
    end
  end

  // Edge detection on the selected clock line
  assign lineLevel  = masterQ ? sckOutQ : sckSync;
  assign edgeOk     = (lineLevel ^ prevLine) && !maskQ && !flagQ && !loadReq && !clrReq;
  assign risingEdge = lineLevel;
  assign sampleEdge = risingEdge ^ modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine <= 1'b0;
    end else begin
      prevLine <= lineLevel;
    end
  end

  // Edge counter and done flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (loadReq || clrReq) begin
        cntQ <= '0;
      end else if (edgeOk) begin
        cntQ <= cntQ + 1'b1;
      end
      if (clrReq) begin
        flagQ <= 1'b0;
      end else if (edgeOk && cntQ == CNT_LAST) begin
        flagQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.load   = loadReq;
    stb.sample = edgeOk && sampleEdge;
    stb.shift  = edgeOk && !sampleEdge;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(cntQ) == CNT_LAST && cntQ == '0);
  // R8
  flag_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq && !loadReq) |=> $stable(cntQ));
  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toggleReq && !cfgWr) |=> sckOutQ != $past(sckOutQ));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !flagQ && cntQ == '0);
  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.sample, stb.shift}));
endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              sckIn,
  input  logic              sdi,
  output logic              sckOut,
  output logic              sdo,
  output logic              irq
);
  localparam int CNT_W = $clog2(2 * DATA_W);
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  dpStrobes_t        stb;
  logic              sdiBit, modeQ, masterQ, flagQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] dataQ, cfgView;
  logic              loadReq, cfgWr, cmdWr;

  assign loadReq = busWrEn && busAddr == ADDR_DATA;
  assign cfgWr   = busWrEn && busAddr == ADDR_CFG;
  assign cmdWr   = busWrEn && busAddr == ADDR_CMD;

  tws_control #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgMode(busWrData[0]), .cfgMaster(busWrData[1]),
    .toggleReq(cmdWr && busWrData[0]), .clrReq(cmdWr && busWrData[1]),
    .loadReq(loadReq), .sckIn(sckIn), .sdiIn(sdi),
    .stb(stb), .sdiBit(sdiBit), .sckOutQ(sckOut),
    .modeQ(modeQ), .masterQ(masterQ), .flagQ(flagQ), .cntQ(cntQ)
  );

  tws_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadByte(busWrData),
    .sdiBit(sdiBit), .dataQ(dataQ), .sdo(sdo)
  );

  always_comb begin
    cfgView          = '0;
    cfgView[0]       = modeQ;
    cfgView[1]       = masterQ;
    cfgView[3]       = flagQ;
    cfgView[4 +: CNT_W] = cntQ;
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA: busRdData = dataQ;
      ADDR_CFG:  busRdData = cfgView;
      default:   busRdData = '0;
    endcase
  end

  assign irq = flagQ;

  // R2
  sdo_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdo == dataQ[DATA_W-1]);
  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(cntQ) == CNT_W'(2 * DATA_W - 1));
endmodule

// File: tb/tws_shift_unit_tb.sv
module tws_shift_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, busWrEn, sckIn, sdi;
  logic [1:0] busAddr;
  logic [7:0] busWrData, busRdData;
  logic       sckOut, sdo, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  tws_shift_unit u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sckIn(sckIn), .sdi(sdi),
    .sckOut(sckOut), .sdo(sdo), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic clkEdge(input bit master);
    if (master) begin
      busWrite(2'd2, 8'h01);
      idle(2);
    end else begin
      @(negedge clk);
      sckIn = ~sckIn;
      idle(5);
    end
  endtask

  task automatic transfer(input bit master, input bit mode, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v;
    busWrite(2'd2, 8'h02);
    sckIn = mode;
    idle(4);
    busWrite(2'd1, {6'd0, master, mode});
    idle(2);
    busWrite(2'd0, tx);
    check("R9 load", sdo, tx[7]);
    for (int i = 0; i < 8; i++) begin
      sdi = rx[7-i];
      idle(4);
      clkEdge(master);
      readReg(2'd1, v);
      check("R4 count", v[7:4], 2*i+1);
      check("R3 sample edge holds", sdo, tx[7-i]);
      clkEdge(master);
      readReg(2'd1, v);
      if (i < 7) begin
        check("R2 shifted msb", sdo, tx[6-i]);
        check("R4 count", v[7:4], 2*i+2);
      end else begin
        check("R5 flag", v[3], 1'b1);
        check("R5 wrap", v[7:4], 4'd0);
        check("R5 irq", irq, 1'b1);
      end
    end
    readReg(2'd0, v);
    check("R2 received byte", v, rx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    rstN = 1'b0; busWrEn = 1'b0; busAddr = 2'd0; busWrData = 8'd0;
    sckIn = 1'b0; sdi = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    readReg(2'd0, v); check("R1 data", v, 8'h00);
    readReg(2'd1, v); check("R1 cfg", v, 8'h00);
    check("R1 sckOut", sckOut, 1'b0);
    check("R1 sdo", sdo, 1'b0);
    check("R1 irq", irq, 1'b0);

    // R6 toggle strobe inverts sckOut
    busWrite(2'd2, 8'h01);
    check("R6 toggle high", sckOut, 1'b1);
    busWrite(2'd2, 8'h01);
    check("R6 toggle low", sckOut, 1'b0);

    // Sweep of modes, master/slave and byte patterns (R3, R10)
    for (int m = 0; m < 2; m++) begin
      for (int md = 0; md < 2; md++) begin
        for (int k = 0; k < 6; k++) begin
          transfer(m[0], md[0], 8'((k * 37 + 5) & 8'hFF), 8'((~(k * 37 + 5)) ^ (k * 11)));
        end
      end
    end

    // R8 edges ignored while flag set (master mode, flag set from last sweep)
    busWrite(2'd1, 8'h02);
    idle(2);
    busWrite(2'd2, 8'h02);
    busWrite(2'd0, 8'hC3);
    for (int i = 0; i < 16; i++) clkEdge(1'b1);
    readReg(2'd0, held);
    check("R8 flag set", irq, 1'b1);
    sdi = ~held[0];
    idle(4);
    clkEdge(1'b1);
    clkEdge(1'b1);
    clkEdge(1'b1);
    readReg(2'd0, v); check("R8 data frozen", v, held);
    readReg(2'd1, v); check("R8 count frozen", v[7:4], 4'd0);

    // R7 clear mid-transfer, then counting resumes from 1
    busWrite(2'd1, 8'h02);
    busWrite(2'd2, 8'h02);
    check("R7 irq low", irq, 1'b0);
    busWrite(2'd0, 8'h96);
    clkEdge(1'b1); clkEdge(1'b1); clkEdge(1'b1);
    readReg(2'd1, v); check("R4 three edges", v[7:4], 4'd3);
    busWrite(2'd2, 8'h02);
    readReg(2'd1, v); check("R7 count cleared", v[7:4], 4'd0);
    clkEdge(1'b1);
    readReg(2'd1, v); check("R7 count resumes", v[7:4], 4'd1);

    // R9 load collides with a detected edge
    busWrite(2'd1, 8'h02);
    idle(2);
    busWrite(2'd0, 8'h11);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 2'd2; busWrData = 8'h01;
    @(negedge clk);
    busAddr = 2'd0; busWrData = 8'h5A;
    @(negedge clk);
    busWrEn = 1'b0;
    readReg(2'd0, v); check("R9 load wins", v, 8'h5A);
    readReg(2'd1, v); check("R9 count zero", v[7:4], 4'd0);

    // R10 config write sets idle level and masks the resulting change
    busWrite(2'd1, 8'h03);
    check("R10 idle level", sckOut, 1'b1);
    idle(2);
    readReg(2'd1, v); check("R10 masked", v[7:4], 4'd0);
    busWrite(2'd1, 8'h02);
    check("R10 idle low", sckOut, 1'b0);
    idle(2);
    readReg(2'd1, v); check("R10 masked back", v[7:4], 4'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule